// File: doc/BRIEF.md
# Calculator Key Command Latch

This block sits between a calculator keypad scanner and the arithmetic sequencer. The scanner delivers a raw key-present detection and a 5-bit key code. The block qualifies each press with a debounce filter that is sampled on a scan tick, and it accepts one command per physical press. It then keeps the pending arithmetic operation in a small set of operation latches. The sequencer reads those latches when the equals command fires.

Add and subtract share a single latch. Multiply, divide and equals each have their own. Entering a new operation replaces the one that is pending. Equals fires for exactly one cycle, with the pending operation still visible, and in the following cycle every operation latch is dropped. There is no power key. The block counts the multiply presses that come straight before equals, so the sequencer can evaluate X^(count+1). Full clear, clear-entry, exchange-operands and return-constant leave as single-cycle requests.

Top module: `calc_cmd_latch`

## Requirements
- R1: After reset all operation flags, `op_equals`, all four request outputs and `rep_count` are 0.
- R2: A press is accepted only when `key_det` has been sampled high on 8 consecutive `scan_tick` cycles. A high run shorter than that produces no effect.
- R3: After an accepted press, and also after reset, no press is accepted until `key_det` has been sampled low on 8 consecutive ticks. A key held down for any length of time therefore acts once.
- R4: Code 16 (multiply), 17 (divide), 18 (add) and 19 (subtract) each set their latch and clear the other operation latches: `op_mul`, `op_div`, and `op_addsub` for both 18 and 19. At most one operation latch is ever set.
- R5: Code 20 (equals) raises `op_equals` for exactly one cycle. In that cycle the pending operation latches and `rep_count` still hold their values. In the next cycle all operation latches and `op_equals` are 0.
- R6: Code 11 (full clear) clears all operation latches and `rep_count`, and pulses `req_clear` for one cycle.
- R7: Code 12 pulses `req_clr_entry`, code 14 pulses `req_xchg` and code 15 pulses `req_rconst`. Each pulse lasts one cycle, comes once per accepted press, and leaves the operation latches unchanged.
- R8: Each accepted multiply increments `rep_count`, and the count saturates at 31.
- R9: Any accepted key other than multiply or equals resets `rep_count` to 0. Equals leaves it unchanged.
- R10: Codes 0 to 10, 13 and 21 to 31 leave the operation latches unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_tick | input | 1 | Debounce sample enable |
| key_det | input | 1 | Raw key-present detection |
| key_code | input | 5 | Code of the key being detected |
| op_addsub | output | 1 | Add/subtract pending |
| op_mul | output | 1 | Multiply pending |
| op_div | output | 1 | Divide pending |
| op_equals | output | 1 | Equals latch, one-cycle result request |
| rep_count | output | 5 | Multiply presses before equals |
| req_clear | output | 1 | Full clear request |
| req_clr_entry | output | 1 | Clear-entry request |
| req_xchg | output | 1 | Exchange-operands request |
| req_rconst | output | 1 | Return-constant request |

## Verification
The hardest state to reach from the ports is a saturated repetition count. Getting there takes more than 31 multiply presses in a row, each needing a full debounced press and a full debounced release, with no other key in between. Random stimulus almost never produces such a run. A directed loop of 35 multiplies drives the count to saturation. An equals press then confirms that the saturated count survives, and a digit press confirms that it is cleared. Random tick spacing and short glitch presses exercise the qualifier, together with the re-arm rule that applies right after reset.

// File: rtl/calc_key_pkg.sv
package calc_key_pkg;

  localparam int KEY_W = 5;

  localparam logic [KEY_W-1:0] KC_FULL_CLR  = 5'd11;
  localparam logic [KEY_W-1:0] KC_CLR_ENTRY = 5'd12;
  localparam logic [KEY_W-1:0] KC_XCHG      = 5'd14;
  localparam logic [KEY_W-1:0] KC_RCONST    = 5'd15;
  localparam logic [KEY_W-1:0] KC_MUL       = 5'd16;
  localparam logic [KEY_W-1:0] KC_DIV       = 5'd17;
  localparam logic [KEY_W-1:0] KC_ADD       = 5'd18;
  localparam logic [KEY_W-1:0] KC_SUB       = 5'd19;
  localparam logic [KEY_W-1:0] KC_EQ        = 5'd20;

  // single-cycle request slots
  localparam int NUM_REQ    = 4;
  localparam int REQ_CLEAR  = 0;
  localparam int REQ_CENTRY = 1;
  localparam int REQ_XCHG   = 2;
  localparam int REQ_RCONST = 3;

  typedef struct packed {
    logic addsub;
    logic mul;
    logic div;
  } op_set_t;

  function automatic logic [KEY_W-1:0] req_code(input int idx);
    logic [KEY_W-1:0] c;
    case (idx)
      REQ_CLEAR:  c = KC_FULL_CLR;
      REQ_CENTRY: c = KC_CLR_ENTRY;
      REQ_XCHG:   c = KC_XCHG;
      default:    c = KC_RCONST;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/calc_key_qual.sv
module calc_key_qual #(
  parameter int DEB_LEN = 8,
  parameter int KEY_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_tick,
  input  logic             key_det,
  input  logic [KEY_W-1:0] key_code,
  output logic             acc,
  output logic [KEY_W-1:0] acc_code
);

  localparam int RUN_W = $clog2(DEB_LEN + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(DEB_LEN);
  localparam logic [RUN_W-1:0] RUN_ONE = RUN_W'(1);

  logic             lvl_q, lvl_d;
  logic [RUN_W-1:0] run_q, run_d;
  logic             armed_q, armed_d;
  logic             acc_q, acc_d;
  logic [KEY_W-1:0] code_q, code_d;

  always_comb begin
    lvl_d   = lvl_q;
    run_d   = run_q;
    armed_d = armed_q;
    acc_d   = 1'b0;
    code_d  = code_q;
    if (scan_tick) begin
      lvl_d = key_det;
      if (key_det != lvl_q)      run_d = RUN_ONE;
      else if (run_q != RUN_MAX) run_d = run_q + RUN_ONE;
      if (run_d == RUN_MAX) begin
        if (!key_det) begin
          armed_d = 1'b1;
        end else if (armed_q) begin
          acc_d   = 1'b1;
          armed_d = 1'b0;
          code_d  = key_code;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= 1'b0;
      run_q   <= '0;
      armed_q <= 1'b0;
      acc_q   <= 1'b0;
      code_q  <= '0;
    end else begin
      lvl_q   <= lvl_d;
      run_q   <= run_d;
      armed_q <= armed_d;
      acc_q   <= acc_d;
      code_q  <= code_d;
    end
  end

  assign acc      = acc_q;
  assign acc_code = code_q;

  AST_ACC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q |=> !acc_q); // R3
  AST_ACC_STABLE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q |-> (lvl_q && run_q == RUN_MAX && !armed_q)); // R2

endmodule

// File: rtl/calc_rep_count.sv
module calc_rep_count #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                        cnt_d = '0;
    else if (step && cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX); // R8
  AST_CNT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == '0); // R9

endmodule

// File: rtl/calc_op_latch.sv
module calc_op_latch
  import calc_key_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic [KEY_W-1:0] code,
  output op_set_t          ops,
  output logic             eq_fire
);

  op_set_t ops_q, ops_d;
  logic    eq_q, eq_d;

  always_comb begin
    ops_d = ops_q;
    eq_d  = 1'b0;
    if (eq_q) ops_d = '0;
    if (acc) begin
      case (code)
        KC_MUL:           ops_d = '{addsub: 1'b0, mul: 1'b1, div: 1'b0};
        KC_DIV:           ops_d = '{addsub: 1'b0, mul: 1'b0, div: 1'b1};
        KC_ADD, KC_SUB:   ops_d = '{addsub: 1'b1, mul: 1'b0, div: 1'b0};
        KC_FULL_CLR:      ops_d = '0;
        KC_EQ:            eq_d  = 1'b1;
        default:          ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ops_q <= '0;
      eq_q  <= 1'b0;
    end else begin
      ops_q <= ops_d;
      eq_q  <= eq_d;
    end
  end

  assign ops     = ops_q;
  assign eq_fire = eq_q;

  AST_OP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ops_q)); // R4
  AST_EQ_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    eq_q |=> (ops_q == '0 && !eq_q)); // R5

endmodule

// File: rtl/calc_cmd_latch.sv
module calc_cmd_latch
  import calc_key_pkg::*;
#(
  parameter int DEB_LEN = 8,
  parameter int CNT_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_tick,
  input  logic             key_det,
  input  logic [4:0]       key_code,
  output logic             op_addsub,
  output logic             op_mul,
  output logic             op_div,
  output logic             op_equals,
  output logic [CNT_W-1:0] rep_count,
  output logic             req_clear,
  output logic             req_clr_entry,
  output logic             req_xchg,
  output logic             req_rconst
);

  logic             acc;
  logic [KEY_W-1:0] acc_code;
  op_set_t          ops;
  logic             eq_fire;
  logic [NUM_REQ-1:0] req_q;

  calc_key_qual #(.DEB_LEN(DEB_LEN), .KEY_W(KEY_W)) qual_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .scan_tick(scan_tick),
    .key_det  (key_det),
    .key_code (key_code),
    .acc      (acc),
    .acc_code (acc_code)
  );

  calc_op_latch op_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .acc    (acc),
    .code   (acc_code),
    .ops    (ops),
    .eq_fire(eq_fire)
  );

  calc_rep_count #(.CNT_W(CNT_W)) rep_i (
    .clk  (clk),
    .rst_n(rst_n),
    .step (acc && acc_code == KC_MUL),
    .clr  (acc && acc_code != KC_MUL && acc_code != KC_EQ),
    .cnt  (rep_count)
  );

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_req
    logic hit;
    assign hit = acc && (acc_code == req_code(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q[i] <= 1'b0;
      else        req_q[i] <= hit;
    end
  end

  assign op_addsub     = ops.addsub;
  assign op_mul        = ops.mul;
  assign op_div        = ops.div;
  assign op_equals     = eq_fire;
  assign req_clear     = req_q[REQ_CLEAR];
  assign req_clr_entry = req_q[REQ_CENTRY];
  assign req_xchg      = req_q[REQ_XCHG];
  assign req_rconst    = req_q[REQ_RCONST];

  AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_q, eq_fire})); // R7
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q != '0) |=> (req_q == '0)); // R7
  AST_CLEAR_OPS: assert property (@(posedge clk) disable iff (!rst_n)
    req_q[REQ_CLEAR] |-> (ops == '0 && rep_count == '0)); // R6

endmodule

// File: tb/calc_cmd_latch_tb_top.sv
`timescale 1ns/1ps
module calc_cmd_latch_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scan_tick = 1'b0;
  logic key_det = 1'b0;
  logic [4:0] key_code = '0;
  logic op_addsub, op_mul, op_div, op_equals;
  logic [4:0] rep_count;
  logic req_clear, req_clr_entry, req_xchg, req_rconst;

  always #2.5 clk = ~clk;

  calc_cmd_latch dut_i (
    .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick), .key_det(key_det),
    .key_code(key_code), .op_addsub(op_addsub), .op_mul(op_mul),
    .op_div(op_div), .op_equals(op_equals), .rep_count(rep_count),
    .req_clear(req_clear), .req_clr_entry(req_clr_entry),
    .req_xchg(req_xchg), .req_rconst(req_rconst)
  );

  int checks = 0;
  int errors = 0;
  bit tick_en = 1'b0;
  bit done = 1'b0;

  // model state
  logic [2:0] m_ops = '0;   // {addsub, mul, div}
  int m_cnt = 0;
  bit m_armed = 1'b0;
  int e_clr = 0, e_ce = 0, e_xc = 0, e_rc = 0, e_res = 0;
  logic [2:0] e_cap_ops = '0;
  int e_cap_cnt = 0;

  // observed
  int n_clr = 0, n_ce = 0, n_xc = 0, n_rc = 0, n_res = 0;
  logic [2:0] cap_ops = '0;
  int cap_cnt = 0;
  bit drain_chk = 1'b0;
  logic [4:0] prev_req = '0;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    scan_tick <= tick_en && (($urandom % 3) != 0);
  end

  // output monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (drain_chk) begin
        check(!op_equals && !op_addsub && !op_mul && !op_div,
              "R5 latches cleared after equals",
              {op_equals, op_addsub, op_mul, op_div}, 0);
        drain_chk = 1'b0;
      end
      if (op_equals) begin
        n_res++;
        cap_ops = {op_addsub, op_mul, op_div};
        cap_cnt = int'(rep_count);
        drain_chk = 1'b1;
      end
      if (req_clear) n_clr++;
      if (req_clr_entry) n_ce++;
      if (req_xchg) n_xc++;
      if (req_rconst) n_rc++;
      if ((prev_req & {op_equals, req_clear, req_clr_entry, req_xchg, req_rconst}) != 0)
        check(1'b0, "R7 request wider than one cycle", 2, 1);
      prev_req = {op_equals, req_clear, req_clr_entry, req_xchg, req_rconst};
    end
  end

  function automatic int sat_inc(input int c);
    return (c >= 31) ? 31 : c + 1;
  endfunction

  task automatic model_key(input logic [4:0] c);
    case (c)
      5'd11: begin m_ops = '0; m_cnt = 0; e_clr++; end
      5'd12: begin m_cnt = 0; e_ce++; end
      5'd14: begin m_cnt = 0; e_xc++; end
      5'd15: begin m_cnt = 0; e_rc++; end
      5'd16: begin m_ops = 3'b010; m_cnt = sat_inc(m_cnt); end
      5'd17: begin m_ops = 3'b001; m_cnt = 0; end
      5'd18, 5'd19: begin m_ops = 3'b100; m_cnt = 0; end
      5'd20: begin e_cap_ops = m_ops; e_cap_cnt = m_cnt; e_res++; m_ops = '0; end
      default: m_cnt = 0;
    endcase
  endtask

  task automatic wait_ticks(input int n);
    int c = 0;
    while (c < n) begin
      @(posedge clk);
      if (scan_tick) c++;
    end
  endtask

  task automatic press(input logic [4:0] c, input int hold);
    @(negedge clk);
    key_code = c;
    key_det = 1'b1;
    wait_ticks(hold);
    @(negedge clk);
    key_det = 1'b0;
    if (hold >= 8 && m_armed) model_key(c);
    wait_ticks(9);
    m_armed = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_state(input string tag);
    check({op_addsub, op_mul, op_div} == m_ops, {tag, " R4,R10 op latches"},
          int'({op_addsub, op_mul, op_div}), int'(m_ops));
    check(int'(rep_count) == m_cnt, {tag, " R8,R9 rep_count"}, int'(rep_count), m_cnt);
    check(n_clr == e_clr, {tag, " R6 req_clear count"}, n_clr, e_clr);
    check(n_ce == e_ce && n_xc == e_xc && n_rc == e_rc, {tag, " R7 request counts"},
          n_ce * 10000 + n_xc * 100 + n_rc, e_ce * 10000 + e_xc * 100 + e_rc);
    check(n_res == e_res, {tag, " R5 result count"}, n_res, e_res);
  endtask

  task automatic check_capture(input string tag);
    check(cap_ops == e_cap_ops, {tag, " R5 ops at equals"}, int'(cap_ops), int'(e_cap_ops));
    check(cap_cnt == e_cap_cnt, {tag, " R5 count at equals"}, cap_cnt, e_cap_cnt);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    finish_run();
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h1A2B3C);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check({op_addsub, op_mul, op_div, op_equals, req_clear, req_clr_entry,
           req_xchg, req_rconst} == 0 && rep_count == 0,
          "R1 reset outputs", int'(rep_count), 0);
    tick_en = 1'b1;

    // R3: key down since reset is not armed
    press(5'd14, 12);
    check(n_xc == 0, "R3 no accept before release after reset", n_xc, 0);

    // R2: short run rejected
    press(5'd16, 5);
    check_state("R2 short run");

    // R3: long hold acts once
    press(5'd14, 40);
    check(n_xc == 1, "R3 long hold one exchange", n_xc, 1);

    // R4 replacement and R7 no effect on latches
    press(5'd18, 9);  check_state("R4 add");
    press(5'd17, 8);  check_state("R4 divide");
    press(5'd15, 10); check_state("R7 rconst keeps divide");
    press(5'd19, 8);  check_state("R4 subtract");
    press(5'd12, 8);  check_state("R7 clear entry");
    press(5'd13, 8);  check_state("R10 negate");

    // power: X * * =
    press(5'd3, 8);
    press(5'd16, 8);
    press(5'd16, 11);
    check(int'(rep_count) == 2, "R8 two multiplies", int'(rep_count), 2);
    press(5'd20, 8);
    check_capture("R5 power");
    check_state("R5 after equals");

    // R8 saturation
    for (int i = 0; i < 35; i++) press(5'd16, 8);
    check(int'(rep_count) == 31, "R8 saturated count", int'(rep_count), 31);
    press(5'd20, 9);
    check_capture("R5 saturated");
    check(int'(rep_count) == 31, "R9 equals keeps count", int'(rep_count), 31);
    press(5'd7, 8);
    check(int'(rep_count) == 0, "R9 digit resets count", int'(rep_count), 0);

    // R6 full clear
    press(5'd16, 8);
    press(5'd11, 8);
    check_state("R6 full clear");

    // random presses
    for (int i = 0; i < 150; i++) begin
      logic [4:0] c;
      int h;
      c = 5'($urandom % 32);
      h = (($urandom % 5) == 0) ? int'(3 + $urandom % 5) : int'(8 + $urandom % 7);
      press(c, h);
      check_state("random");
      if (c == 5'd20 && h >= 8) check_capture("random equals");
    end

    finish_run();
  end

endmodule